// File: doc/BRIEF.md
# Pipelined Binary to Decimal Digit Converter

This block converts an 8-bit unsigned binary value into three packed binary-coded decimal digits: hundreds, tens and units, in a 12-bit word. It uses the shift-and-add-3 method, unrolled into a fixed network of conditional adjust cells. An adjust cell appears only where an adjustment can ever be needed, so the network has seven cells. The network is cut by registers into a six-stage pipeline, which keeps the logic between flops short.

A producer presents a value on `in_data` and raises `in_valid` for one cycle. The converted result appears on `out_bcd` with `out_valid` high exactly six cycles later. A new value may be presented in every cycle, with no stall and no back-pressure. A synchronous reset clears every valid bit in the pipeline, and any conversion still in flight is dropped.

Top module: `bin2bcd_pipe`

## Requirements
- R1: `out_bcd` holds the hundreds digit in bits 11:8, the tens digit in bits 7:4 and the units digit in bits 3:0. Each digit is binary coded, in the range 0 to 9.
- R2: For every input value v from 0 to 255, the result has hundreds = v/100, tens = (v/10)%10 and units = v%10.
- R3: Whenever `out_valid` is high, bits 11 and 10 of `out_bcd` are zero and bit 0 equals bit 0 of the input being converted.
- R4: An input accepted with `in_valid` high at a clock edge produces exactly one `out_valid` pulse. The result is visible after the sixth edge counted from and including the accepting edge.
- R5: Inputs may be presented on consecutive cycles. Each one is converted and emitted in order, with none lost or merged.
- R6: In a cycle where `in_valid` is low, `in_data` is ignored and produces no output pulse.
- R7: While `rst` is high at a clock edge, all valid bits are cleared. `out_valid` stays low until an input accepted after reset has travelled the full pipeline, and conversions in flight at reset never emerge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 8 | Unsigned binary value |
| out_valid | output | 1 | Result word is valid this cycle |
| out_bcd | output | 12 | Packed decimal digits {hundreds, tens, units} |

## Verification
Two functions can fall in the same cycle: accepting a fresh input, and clearing the pipeline on reset. Both can also coincide with the emission of an older result. The bench raises reset while values are in flight and a new value is presented on the same edge. It then judges that none of those values ever appears at the output and that the first input after reset emerges on time. It also runs an unbroken stream of all 256 values, so an acceptance and an emission happen in every cycle. Every emitted word is compared with the expected digits at its expected cycle.

// File: rtl/bin2bcd_pipe.sv
module bin2bcd_pipe (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        out_valid,
  output logic [11:0] out_bcd
);

  // add-3 cell in gate form: 0..4 pass, 5..9 -> 8..12
  function automatic logic [3:0] adj(input logic [3:0] b);
    logic [3:0] o;
    o[3] = b[3] | (b[2] & b[0]) | (b[2] & b[1]);
    o[2] = (b[3] & b[0]) | (b[2] & ~b[1] & ~b[0]);
    o[1] = (b[3] & ~b[0]) | (~b[2] & b[1]) | (b[1] & b[0]);
    o[0] = (b[3] & ~b[0]) | (~b[3] & ~b[2] & b[0]) | (b[2] & b[1] & ~b[0]);
    return o;
  endfunction

  logic [5:0] vld;

  logic [7:0] s1_bin;

  logic [3:0] s2_c0;
  logic [4:0] s2_bin;

  logic [3:0] s3_c1;
  logic       s3_m0;
  logic [3:0] s3_bin;

  logic [3:0] s4_c2;
  logic       s4_m0, s4_m1;
  logic [2:0] s4_bin;

  logic [3:0] s5_c3, s5_c5;
  logic [1:0] s5_bin;

  logic [11:0] s6_bcd;

  logic [3:0] c0, c1, c2, c3, c4, c5, c6;

  assign c0 = adj({1'b0, s1_bin[7:5]});
  assign c1 = adj({s2_c0[2:0], s2_bin[4]});
  assign c2 = adj({s3_c1[2:0], s3_bin[3]});
  assign c3 = adj({s4_c2[2:0], s4_bin[2]});
  assign c5 = adj({1'b0, s4_m0, s4_m1, s4_c2[3]});
  assign c4 = adj({s5_c3[2:0], s5_bin[1]});
  assign c6 = adj({s5_c5[2:0], s5_c3[3]});

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[4:0], in_valid};
  end

  always_ff @(posedge clk) begin
    s1_bin <= in_data;

    s2_c0  <= c0;
    s2_bin <= s1_bin[4:0];

    s3_c1  <= c1;
    s3_m0  <= s2_c0[3];
    s3_bin <= s2_bin[3:0];

    s4_c2  <= c2;
    s4_m0  <= s3_m0;
    s4_m1  <= s3_c1[3];
    s4_bin <= s3_bin[2:0];

    s5_c3  <= c3;
    s5_c5  <= c5;
    s5_bin <= s4_bin[1:0];

    s6_bcd <= {2'b00, s5_c5[3], c6, c4, s5_bin[0]};
  end

  assign out_valid = vld[5];
  assign out_bcd   = s6_bcd;

endmodule

// File: rtl/bin2bcd_pipe_chk.sv
module bin2bcd_pipe_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [7:0]  in_data,
  input logic        out_valid,
  input logic [11:0] out_bcd
);

  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  logic [9:0] dec_val;
  assign dec_val = 10'(out_bcd[11:8]) * 10'd100 + 10'(out_bcd[7:4]) * 10'd10 + 10'(out_bcd[3:0]);

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_bcd[7:4] <= 4'd9 && out_bcd[3:0] <= 4'd9 && out_bcd[11:8] <= 4'd2)); // R1
  AST_VALUE_MATCH: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd6 && out_valid) |-> (dec_val == 10'($past(in_data, 6)))); // R2
  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_bcd[11:10] == 2'b00)); // R3
  AST_LSB_PASS: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd6 && out_valid) |-> (out_bcd[0] == $past(in_data[0], 6))); // R3
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd6) |-> (out_valid == $past(in_valid, 6))); // R4
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    (since_rst < 3'd6) |-> !out_valid); // R7

endmodule

bind bin2bcd_pipe bin2bcd_pipe_chk chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_bcd(out_bcd)
);

// File: tb/bin2bcd_pipe_tb_top.sv
module bin2bcd_pipe_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic [11:0] out_bcd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  bin2bcd_pipe dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_bcd(out_bcd)
  );

  // history of what each edge sampled
  int       edge_n = 0;
  int       last_rst = 0;
  bit       vh [0:7];
  bit [7:0] dh [0:7];
  int       outs = 0;
  bit       seen [0:255];

  always @(posedge clk) begin
    edge_n = edge_n + 1;
    vh[edge_n % 8] = in_valid;
    dh[edge_n % 8] = in_data;
    if (rst) last_rst = edge_n;
  end

  function automatic bit [11:0] ref_bcd(input bit [7:0] v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  // monitor: result visible after edge m reflects input sampled at edge m-5
  always @(negedge clk) begin
    if (edge_n >= 6 && !done) begin
      int  e;
      bit  expv;
      bit [7:0] v;
      e    = edge_n - 5;
      expv = vh[e % 8] && (e > last_rst);
      v    = dh[e % 8];
      chk(out_valid == expv, "R4/R6/R7 valid timing", int'(out_valid), int'(expv));
      if (expv && out_valid) begin
        outs++;
        seen[v] = 1'b1;
        chk(out_bcd == ref_bcd(v), "R1/R2 digits", int'(out_bcd), int'(ref_bcd(v)));
        chk(out_bcd[11:10] == 2'b00 && out_bcd[0] == v[0], "R3 fixed bits",
            int'({out_bcd[11:10], out_bcd[0]}), int'({2'b00, v[0]}));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'hA5;
    end
  endtask

  task automatic send(input bit [7:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 reset state", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    idle(8);
    chk(outs == 0, "R7 no output after reset", outs, 0);
  endtask

  task automatic t_corners;
    int base;
    base = outs;
    foreach (seen[i]) seen[i] = 1'b0;
    send(8'd0);   idle(2);
    send(8'd9);   idle(1);
    send(8'd10);  idle(3);
    send(8'd99);  idle(1);
    send(8'd100); idle(2);
    send(8'd199); idle(1);
    send(8'd200); idle(1);
    send(8'd255); idle(9);
    chk(outs - base == 8, "R4 one output per corner input", outs - base, 8);
    chk(seen[0] && seen[99] && seen[100] && seen[255], "R2 corner values emitted", 0, 1);
  endtask

  task automatic t_sweep_b2b;
    int base;
    base = outs;
    foreach (seen[i]) seen[i] = 1'b0;
    for (int v = 0; v < 256; v++) send(8'(v));
    idle(9);
    chk(outs - base == 256, "R5 back-to-back count", outs - base, 256);
    begin
      int miss;
      miss = 0;
      foreach (seen[i]) if (!seen[i]) miss++;
      chk(miss == 0, "R2 all 256 values converted", miss, 0);
    end
  endtask

  task automatic t_gaps;
    int base;
    base = outs;
    for (int v = 255; v >= 0; v -= 7) begin
      send(8'(v));
      idle(v % 4);
    end
    idle(9);
    chk(outs - base == 37, "R5 gapped stream count", outs - base, 37);
  endtask

  task automatic t_ignore_idle;
    int base;
    base = outs;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'(k * 13);
    end
    idle(8);
    chk(outs == base, "R6 data ignored without valid", outs - base, 0);
  endtask

  task automatic t_reset_midflight;
    int base;
    base = outs;
    send(8'd17); send(8'd42); send(8'd123);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_data = 8'd77;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b1; in_data = 8'd238;
    idle(10);
    chk(outs - base == 1, "R7 in-flight dropped, next emitted", outs - base, 1);
    chk(seen[238] == 1'b1, "R7 post-reset value seen", int'(seen[238]), 1);
  endtask

  initial begin
    t_reset;
    t_corners;
    t_sweep_b2b;
    t_gaps;
    t_ignore_idle;
    foreach (seen[i]) seen[i] = 1'b0;
    t_reset_midflight;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule